// File: doc/BRIEF.md
# Block-scaled 6-bit float to FP32 dequantizer

This block takes one packed block of thirty-two 6-bit floating-point element codes and the 8-bit power-of-two exponent they share. It expands each element into an IEEE single-precision word. The shared exponent is applied by adding it to the element's own exponent, so the path has no multiplier. A compile-time parameter selects the element layout. One layout has three exponent bits and two mantissa bits. The other has two exponent bits and three mantissa bits.

A block is taken in with a single valid/ready handshake. The decoded words then leave over a valid/ready stream, `LANES` words per beat, in ascending element order. The input is ready again on the beat that carries the last words of the current block, so consecutive blocks stream with no idle cycle between them.

Subnormal element codes are normalized into FP32 after the shared exponent is applied. The shared-exponent code 0xFF marks the whole block as not-a-number. Results below the FP32 normal range become signed zero, and results above it become signed infinity.

Top module: `mf6_dequant`

## Requirements
- R1: Out of reset `in_ready` is 1 and `out_valid` is 0. A block is captured on a cycle with `in_valid` and `in_ready` both high, and `out_valid` is 1 from the next cycle on.
- R2: Element i sits in `in_codes[6i+5:6i]`. Beat b carries element b*LANES+k on `out_data[32k+31:32k]`. The block takes 32/LANES beats, `out_last` is 1 on the final beat only, and `out_valid` falls after that beat is taken unless a new block was captured.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R4: In the default layout (three exponent bits), bit 5 is the sign, bits 4:2 are the exponent e with bias 3, and bits 1:0 are the mantissa m. The all-ones exponent is an ordinary finite value. If e is nonzero, the FP32 exponent field is scale+e-3 and the fraction is m at its top.
- R5: An element with e=0 and m nonzero is normalized. The value m·2^(1-bias-mantissa_bits) is shifted until its leading one becomes the implicit bit, and the FP32 exponent field is reduced by the same amount.
- R6: An element with e=0 and m=0 gives FP32 zero with the element's sign bit, so code 0x20 gives 0x80000000.
- R7: A shared exponent code of 0xFF makes every word of the block 0x7FC00000.
- R8: A result whose FP32 exponent field would be 0 or less becomes zero with the element's sign. No FP32 subnormal is ever produced.
- R9: A result whose FP32 exponent field would be 255 or more becomes infinity with the element's sign.
- R10: On the beat with `out_last`, `out_ready` 1 makes `in_ready` 1. A block offered on that cycle is taken, and its beat 0 appears on the next cycle.
- R11: In the alternate layout (parameter FMT = FMT_E2M3), bits 4:3 are the exponent with bias 1 and bits 2:0 are the mantissa. R4 to R9 apply to it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packed block offered |
| in_ready | output | 1 | Block can be taken this cycle |
| in_scale | input | 8 | Shared power-of-two exponent, bias 127, 0xFF reserved |
| in_codes | input | 6*NUM_ELEM | Element codes, element 0 in the low bits |
| out_valid | output | 1 | Decoded words present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 32*LANES | FP32 words, lane 0 in the low bits |
| out_last | output | 1 | Final beat of the block |

## Verification
The decode path is combinational from the held block, so beat 0 of a block is due one clock after the handshake that captures it. Each later beat is due one clock after the previous beat is taken, and a stalled beat stays until it is taken. The bench drives inputs on the falling edge and samples on the next falling edge, after exactly one register has been updated. It checks every lane of every beat against an independent model. The model finds the leading one of the full significand with a loop, instead of treating normal and subnormal codes separately. A stall test checks that the data are unchanged across two held cycles. A chained test checks that no cycle is lost between blocks.

// File: rtl/mf6_pkg.sv
package mf6_pkg;

  typedef enum logic { FMT_E3M2 = 1'b0, FMT_E2M3 = 1'b1 } mf6_fmt_e;

  typedef struct packed {
    logic [31:0] word;
    logic        flush;
    logic        ovf;
  } mf6_dec_t;

  localparam logic [31:0] MF6_QNAN = 32'h7FC0_0000;

  // Expand one element code to FP32, with the shared exponent folded into the
  // exponent field and subnormal element codes normalized.
  function automatic mf6_dec_t mf6_decode(mf6_fmt_e fmt, logic [7:0] sc,
                                          logic [5:0] code);
    mf6_dec_t    r;
    logic [2:0]  ef;
    logic [2:0]  mf;
    logic [25:0] sh;
    int          mw;
    int          eb;
    int          lead;
    int          bexp;
    mw = (fmt == FMT_E2M3) ? 3 : 2;
    eb = (fmt == FMT_E2M3) ? 1 : 3;
    if (fmt == FMT_E2M3) begin
      ef = {1'b0, code[4:3]};
      mf = code[2:0];
    end else begin
      ef = code[4:2];
      mf = {1'b0, code[1:0]};
    end
    r = '0;
    r.word[31] = code[5];
    if (sc == 8'hFF) begin
      r.word = MF6_QNAN;
    end else if (ef != 3'd0 || mf != 3'd0) begin
      if (ef != 3'd0) begin
        bexp = int'(sc) + int'(ef) - eb;
        sh   = 26'(mf) << (23 - mw);
      end else begin
        lead = mf[2] ? 2 : (mf[1] ? 1 : 0);
        bexp = int'(sc) + lead + 1 - eb - mw;
        sh   = 26'(mf) << (23 - lead);
      end
      if (bexp <= 0) begin
        r.flush = 1'b1;
      end else if (bexp >= 255) begin
        r.word[30:23] = 8'hFF;
        r.ovf = 1'b1;
      end else begin
        r.word[30:23] = 8'(bexp);
        r.word[22:0]  = sh[22:0];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mf6_lane_decode.sv
module mf6_lane_decode
  import mf6_pkg::*;
#(
  parameter mf6_fmt_e FMT = FMT_E3M2
) (
  input  logic [7:0]  scale,
  input  logic [5:0]  code,
  output logic [31:0] fp32,
  output logic        flushed,
  output logic        overflowed
);
  mf6_dec_t dec;

  always_comb begin
    dec        = mf6_decode(FMT, scale, code);
    fp32       = dec.word;
    flushed    = dec.flush;
    overflowed = dec.ovf;
  end
endmodule

// File: rtl/mf6_block_hold.sv
module mf6_block_hold #(
  parameter int NUM_ELEM = 32,
  parameter int LANES    = 4,
  localparam int BEATS   = NUM_ELEM / LANES,
  localparam int BW      = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int CW      = 6 * NUM_ELEM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_scale,
  input  logic [CW-1:0]    in_codes,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  output logic [7:0]       scale_q,
  output logic [6*LANES-1:0] lane_codes
);
  logic          busy_q;
  logic [BW-1:0] beat_q;
  logic [CW-1:0] codes_q;
  logic          take_in;
  logic          take_out;
  logic          at_last;

  assign at_last   = (beat_q == BW'(BEATS - 1));
  assign out_valid = busy_q;
  assign out_last  = busy_q && at_last;
  assign in_ready  = !busy_q || (out_ready && at_last);
  assign take_in   = in_valid && in_ready;
  assign take_out  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      scale_q <= '0;
      codes_q <= '0;
    end else if (take_in) begin
      busy_q  <= 1'b1;
      beat_q  <= '0;
      scale_q <= in_scale;
      codes_q <= in_codes;
    end else if (take_out) begin
      if (at_last) busy_q <= 1'b0;
      else         beat_q <= beat_q + 1'b1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_sel
    assign lane_codes[6*k +: 6] = codes_q[6*(int'(beat_q)*LANES + k) +: 6];
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_beat_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(beat_q) < BEATS));
  assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !in_valid) |=> !out_valid);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(beat_q)));
  assert_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |-> in_ready);
endmodule

// File: rtl/mf6_dequant.sv
module mf6_dequant
  import mf6_pkg::*;
#(
  parameter mf6_fmt_e FMT      = FMT_E3M2,
  parameter int       NUM_ELEM = 32,
  parameter int       LANES    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_scale,
  input  logic [6*NUM_ELEM-1:0] in_codes,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [32*LANES-1:0]   out_data,
  output logic                  out_last
);
  logic [7:0]         scale_q;
  logic [6*LANES-1:0] lane_codes;
  logic [LANES-1:0]   lane_flush;
  logic [LANES-1:0]   lane_ovf;

  mf6_block_hold #(.NUM_ELEM(NUM_ELEM), .LANES(LANES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_scale  (in_scale),
    .in_codes  (in_codes),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .scale_q   (scale_q),
    .lane_codes(lane_codes)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mf6_lane_decode #(.FMT(FMT)) u_dec (
      .scale     (scale_q),
      .code      (lane_codes[6*k +: 6]),
      .fp32      (out_data[32*k +: 32]),
      .flushed   (lane_flush[k]),
      .overflowed(lane_ovf[k])
    );

    assert_no_denorm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !((out_data[32*k+23 +: 8] == 8'h00) && (out_data[32*k +: 23] != 23'd0)));
    assert_flush_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && lane_flush[k]) |->
        (out_data[32*k +: 31] == 31'd0 && out_data[32*k+31] == lane_codes[6*k+5]));
    assert_inf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && lane_ovf[k]) |-> (out_data[32*k +: 31] == 31'h7F80_0000));
    assert_nan_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && scale_q == 8'hFF) |-> (out_data[32*k +: 32] == MF6_QNAN));
  end

  assert_stall_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: tb/tb_mf6_dequant.sv
module tb_mf6_dequant;
  import mf6_pkg::*;

  localparam int NE    = 32;
  localparam int LANES = 4;
  localparam int BEATS = NE / LANES;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [7:0]         in_scale = '0;
  logic [6*NE-1:0]    in_codes = '0;
  logic               out_ready = 1'b0;
  logic               in_ready_a, in_ready_b;
  logic               out_valid_a, out_valid_b;
  logic               out_last_a, out_last_b;
  logic [32*LANES-1:0] out_data_a, out_data_b;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mf6_dequant #(.FMT(FMT_E3M2), .NUM_ELEM(NE), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_a),
    .in_scale(in_scale), .in_codes(in_codes), .out_valid(out_valid_a),
    .out_ready(out_ready), .out_data(out_data_a), .out_last(out_last_a));

  mf6_dequant #(.FMT(FMT_E2M3), .NUM_ELEM(NE), .LANES(LANES)) dut_e2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_scale(in_scale), .in_codes(in_codes), .out_valid(out_valid_b),
    .out_ready(out_ready), .out_data(out_data_b), .out_last(out_last_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Model: full significand, leading one found by scanning.
  function automatic logic [31:0] model(input bit alt, input logic [7:0] sc,
                                        input logic [5:0] c);
    int mw, eb, e, m, sig, q, b;
    logic [31:0] w;
    mw = alt ? 3 : 2;
    eb = alt ? 1 : 3;
    e  = alt ? int'(c[4:3]) : int'(c[4:2]);
    m  = alt ? int'(c[2:0]) : int'(c[1:0]);
    if (sc == 8'hFF) return 32'h7FC0_0000;
    sig = (e != 0) ? ((1 << mw) | m) : m;
    w = {c[5], 31'd0};
    if (sig == 0) return w;
    q = 0;
    for (int i = 0; i < 8; i++) if ((sig >> i) & 1) q = i;
    b = int'(sc) + ((e != 0) ? e : 1) - eb - mw + q;
    if (b <= 0) return w;
    if (b >= 255) return {c[5], 8'hFF, 23'd0};
    w[30:23] = 8'(b);
    w[22:0]  = 23'((sig << (23 - q)) & 32'h007F_FFFF);
    return w;
  endfunction

  task automatic check_beat(input int b, input logic [7:0] sc,
                            input logic [6*NE-1:0] codes, input string req);
    chk(out_valid_a && out_valid_b, {req, " R2 valid"},
        {30'd0, out_valid_a, out_valid_b}, 32'd3);
    chk(out_last_a == (b == BEATS-1) && out_last_b == (b == BEATS-1),
        {req, " R2 last"}, {30'd0, out_last_a, out_last_b},
        (b == BEATS-1) ? 32'd3 : 32'd0);
    for (int k = 0; k < LANES; k++) begin
      logic [5:0] c;
      c = codes[6*(b*LANES+k) +: 6];
      chk(out_data_a[32*k +: 32] == model(1'b0, sc, c), {req, " R4"},
          out_data_a[32*k +: 32], model(1'b0, sc, c));
      chk(out_data_b[32*k +: 32] == model(1'b1, sc, c), {req, " R11"},
          out_data_b[32*k +: 32], model(1'b1, sc, c));
    end
  endtask

  // Drive a block at a falling edge and drain it; stall_at < 0 means no stall.
  task automatic run_block(input logic [7:0] sc, input logic [6*NE-1:0] codes,
                           input int stall_at, input string req);
    logic [32*LANES-1:0] snap;
    @(negedge clk);
    chk(in_ready_a && in_ready_b, "R1 ready when idle",
        {30'd0, in_ready_a, in_ready_b}, 32'd3);
    in_valid = 1'b1; in_scale = sc; in_codes = codes;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    for (int b = 0; b < BEATS; b++) begin
      if (b == stall_at) begin
        out_ready = 1'b0;
        snap = out_data_a;
        repeat (2) begin
          @(posedge clk); @(negedge clk);
          chk(out_valid_a && out_data_a == snap, "R3 stall hold",
              out_data_a[31:0], snap[31:0]);
        end
      end
      check_beat(b, sc, codes, req);
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b0;
    chk(!out_valid_a && !out_valid_b, "R2 drained",
        {30'd0, out_valid_a, out_valid_b}, 32'd0);
  endtask

  function automatic logic [6*NE-1:0] fill(input logic [5:0] c);
    logic [6*NE-1:0] v;
    for (int i = 0; i < NE; i++) v[6*i +: 6] = c;
    return v;
  endfunction

  function automatic logic [6*NE-1:0] mix(input int mul, input int add);
    logic [6*NE-1:0] v;
    for (int i = 0; i < NE; i++) v[6*i +: 6] = 6'((i*mul + add) % 64);
    return v;
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk(in_ready_a == 1'b1, "R1 reset ready", {31'd0, in_ready_a}, 32'd1);
    chk(out_valid_a == 1'b0 && out_valid_b == 1'b0, "R1 reset valid",
        {30'd0, out_valid_a, out_valid_b}, 32'd0);
  endtask

  task automatic test_literals();
    logic [6*NE-1:0] v;
    v = fill(6'b001100);
    v[6 +: 6] = 6'b000001; v[12 +: 6] = 6'b011111; v[18 +: 6] = 6'b100000;
    @(negedge clk);
    in_valid = 1'b1; in_scale = 8'd127; in_codes = v;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid_a, "R1 valid after capture", {31'd0, out_valid_a}, 32'd1);
    chk(out_data_a[31:0] == 32'h3F80_0000, "R4 one", out_data_a[31:0], 32'h3F80_0000);
    chk(out_data_a[63:32] == 32'h3D80_0000, "R5 subnormal", out_data_a[63:32], 32'h3D80_0000);
    chk(out_data_a[95:64] == 32'h41E0_0000, "R4 all-ones exp", out_data_a[95:64], 32'h41E0_0000);
    chk(out_data_a[127:96] == 32'h8000_0000, "R6 neg zero", out_data_a[127:96], 32'h8000_0000);
    chk(out_data_b[31:0] == 32'h3FC0_0000, "R11 normal", out_data_b[31:0], 32'h3FC0_0000);
    chk(out_data_b[63:32] == 32'h3E00_0000, "R11 subnormal", out_data_b[63:32], 32'h3E00_0000);
    chk(out_data_b[95:64] == 32'h40F0_0000, "R11 max", out_data_b[95:64], 32'h40F0_0000);
    out_ready = 1'b1;
    repeat (BEATS) @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid_a, "R2 drained after literals", {31'd0, out_valid_a}, 32'd0);
  endtask

  task automatic test_nan();
    run_block(8'hFF, mix(5, 1), -1, "R7 nan block");
    chk(model(1'b0, 8'hFF, 6'd12) == 32'h7FC0_0000, "R7 model nan",
        model(1'b0, 8'hFF, 6'd12), 32'h7FC0_0000);
  endtask

  task automatic test_back_to_back();
    logic [6*NE-1:0] c1, c2;
    c1 = mix(3, 2); c2 = mix(11, 7);
    @(negedge clk);
    in_valid = 1'b1; in_scale = 8'd120; in_codes = c1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    for (int b = 0; b < BEATS; b++) begin
      check_beat(b, 8'd120, c1, "R10 first");
      out_ready = 1'b1;
      if (b == BEATS-1) begin
        chk(in_ready_a && in_ready_b, "R10 ready on last",
            {30'd0, in_ready_a, in_ready_b}, 32'd3);
        in_valid = 1'b1; in_scale = 8'd135; in_codes = c2;
      end
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
    for (int b = 0; b < BEATS; b++) begin
      check_beat(b, 8'd135, c2, "R10 second");
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b0;
    chk(!out_valid_a, "R10 drained", {31'd0, out_valid_a}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    test_reset();
    test_literals();
    run_block(8'd127, fill(6'b001100), -1, "R4 ones");
    run_block(8'd130, mix(7, 3), -1, "R5 R6 spread");
    run_block(8'd100, mix(1, 0), -1, "R5 all codes");
    test_nan();
    run_block(8'd0, mix(1, 0), -1, "R8 underflow scale0");
    run_block(8'd1, mix(9, 4), -1, "R8 underflow scale1");
    run_block(8'd254, mix(1, 32), -1, "R9 overflow");
    run_block(8'd127, mix(13, 5), 3, "R3 stall");
    test_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule